// File: doc/BRIEF.md
# LPC Memory Cycle Target

This block is the target end of a Low Pin Count bus that sits in front of a byte-wide flash array. It watches the active-low frame strobe and the 4-bit multiplexed bus and decodes memory read and memory write cycles. For each cycle it gathers the 32-bit address and, on a write, the data byte. It then answers on the bus with sync, read data and turnaround nibbles. The bus is split into an input nibble, an output nibble and an output enable, so the pad logic can combine them.

The back end is a plain strobe interface to the array: an address, write data, a single-cycle write strobe, a single-cycle read strobe, and read data that returns one clock after the read strobe. The block claims only two address windows. After it accepts a write, it models the internal program/erase time with a cycle counter. While that counter runs, claimed reads return a status byte whose bit 6 flips on every read.

Top module: `lpc_mem_target`

## Requirements
- R1: A cycle starts on a clock where `frame_n` is low and `lad_in` is 0000b. The nibble in the next clock selects the cycle type: 010Xb is a memory read and 011Xb is a memory write. Any other type makes the block go idle without driving the bus or pulsing a strobe.
- R2: The address arrives over clocks 2 to 9 of the cycle (the start clock is clock 0), most significant nibble first. Write data arrives over clocks 10 and 11, bits 3:0 first. Read data is returned bits 3:0 first.
- R3: A cycle is claimed only for addresses FFC00000h to FFFFFFFFh or 000E0000h to 000FFFFFh. For any other address `lad_oe` stays low for the whole cycle and no array strobe is pulsed.
- R4: On a claimed read, the block drives 0000b in clock 12, the data low nibble in clock 13, the data high nibble in clock 14 and 1111b in clock 15. `lad_oe` is high in exactly those four clocks.
- R5: On a claimed write, the block drives 0000b in clock 14 and 1111b in clock 15. `lad_oe` is high in exactly those two clocks.
- R6: On a claimed write, `mem_we` pulses once, in clock 12, with `mem_addr` equal to the address bits [ARRAY_AW-1:0] and `mem_wdata` equal to the byte. On a claimed read, `mem_re` pulses in clock 10, and the array data one clock later is the byte returned.
- R7: For BUSY_CYCLES clocks after a write strobe, claimed reads return the status byte {0, t, 000000b}, with bit 6 equal to a flag t. The flag is 0 after reset and inverts after each such read. The array is not read.
- R8: Once the busy count has expired, claimed reads return array data again, and the status flag no longer changes.
- R9: A claimed write whose clock 12 falls inside the busy period still receives sync, but it produces no `mem_we` and leaves the array unchanged.
- R10: `frame_n` low in any clock of a cycle other than the start clock aborts the cycle. `lad_oe` is low in the next clock and no later strobe of that cycle is issued. If `lad_in` is 0000b in that clock, it counts as a new start.
- R11: Asynchronous active-low `rst_n` returns the block to idle with `lad_oe`, `mem_we` and `mem_re` low. It also clears the busy count and the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven onto the bus when enabled |
| lad_oe | output | 1 | Bus output enable |
| mem_addr | output | ARRAY_AW | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one clock |
| mem_re | output | 1 | Array read strobe, one clock |
| mem_rdata | input | 8 | Array read data, valid the clock after `mem_re` |

## Verification
The bench builds the block with BUSY_CYCLES = 40 and the default ARRAY_AW of 18. A busy period of 40 clocks covers exactly two back-to-back 17-clock reads after a write, and ends just before the third. One sequence therefore shows both phases of the status flag and then the return of array data. The short window also lets the bench place a second write inside the busy period, and it keeps the wait after each table write short enough to run many vectors.

// File: rtl/lpc_mem_target.sv
module lpc_mem_target #(
  parameter int ARRAY_AW    = 18,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic [3:0]          lad_in,
  output logic [3:0]          lad_out,
  output logic                lad_oe,
  output logic [ARRAY_AW-1:0] mem_addr,
  output logic [7:0]          mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [7:0]          mem_rdata
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [3:0] {
    IDLE, CTYPE, ADDR, WDLO, WDHI, TAR1, TAR2,
    SYNC, RDLO, RDHI, TARB1, TARB2
  } state_t;

  state_t        state;
  logic [2:0]    nib;
  logic [31:0]   addr_q;
  logic [7:0]    wdata_q, rdata_q;
  logic          is_wr, tog, stat_rd;
  logic [CW-1:0] busy_cnt;

  wire busy = busy_cnt != '0;
  wire hit  = (addr_q[31:22] == 10'h3FF) || (addr_q[31:17] == 15'd7);

  assign mem_addr  = addr_q[ARRAY_AW-1:0];
  assign mem_wdata = wdata_q;
  assign mem_we    = (state == TAR1) && is_wr && hit && !busy;
  assign mem_re    = (state == TAR1) && !is_wr && hit && !busy;
  assign lad_oe    = hit && (state inside {SYNC, RDLO, RDHI, TARB1});

  always_comb begin
    case (state)
      SYNC:    lad_out = 4'h0;
      RDLO:    lad_out = rdata_q[3:0];
      RDHI:    lad_out = rdata_q[7:4];
      default: lad_out = 4'hF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      nib      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      is_wr    <= 1'b0;
      tog      <= 1'b0;
      stat_rd  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (mem_we)    busy_cnt <= CW'(BUSY_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - CW'(1);

      if (state != IDLE && !frame_n) begin
        state <= (lad_in == 4'h0) ? CTYPE : IDLE;
      end else begin
        case (state)
          IDLE:  if (!frame_n && lad_in == 4'h0) state <= CTYPE;
          CTYPE: begin
            nib <= '0;
            if (lad_in[3:1] == 3'b010) begin
              is_wr <= 1'b0;
              state <= ADDR;
            end else if (lad_in[3:1] == 3'b011) begin
              is_wr <= 1'b1;
              state <= ADDR;
            end else begin
              state <= IDLE;
            end
          end
          ADDR: begin
            addr_q <= {addr_q[27:0], lad_in};
            nib    <= nib + 3'd1;
            if (nib == 3'd7) state <= is_wr ? WDLO : TAR1;
          end
          WDLO: begin
            wdata_q[3:0] <= lad_in;
            state        <= WDHI;
          end
          WDHI: begin
            wdata_q[7:4] <= lad_in;
            state        <= TAR1;
          end
          TAR1: begin
            stat_rd <= busy;
            state   <= TAR2;
          end
          TAR2: begin
            if (!is_wr && hit) begin
              if (stat_rd) begin
                rdata_q <= {1'b0, tog, 6'b0};
                tog     <= ~tog;
              end else begin
                rdata_q <= mem_rdata;
              end
            end
            state <= SYNC;
          end
          SYNC:    state <= is_wr ? TARB1 : RDLO;
          RDLO:    state <= RDHI;
          RDHI:    state <= TARB1;
          TARB1:   state <= TARB2;
          default: state <= IDLE;
        endcase
      end
    end
  end
endmodule

module lpc_mem_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       mem_we
);
  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  // R4
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == 4'h0);

  // R5
  release_after_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lad_oe) && $past(frame_n) |-> $past(lad_out) == 4'hF);

  // R6
  we_then_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && frame_n ##1 frame_n |=> lad_oe && lad_out == 4'h0);
endmodule

bind lpc_mem_target lpc_mem_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
  .lad_out(lad_out), .lad_oe(lad_oe), .mem_we(mem_we)
);

// File: tb/lpc_mem_target_tb_top.sv
module lpc_mem_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 18;
  localparam int BUSY = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1;
  logic [3:0]    lad_in = 4'hF;
  logic [3:0]    lad_out;
  logic          lad_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_we, mem_re;
  logic [7:0]    mem_rdata = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_mem_target #(.ARRAY_AW(AW), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] init_byte(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  logic [7:0] arr [256];
  logic       loaded = 1'b0;
  always @(posedge clk) begin
    if (!loaded) begin
      for (int i = 0; i < 256; i++) arr[i] <= init_byte(i);
      loaded <= 1'b1;
    end else begin
      if (mem_we) arr[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= arr[mem_addr[7:0]];
    end
  end

  int we_cnt = 0, re_cnt = 0;
  logic [AW-1:0] we_addr;
  logic [7:0]    we_data;
  always @(negedge clk) begin
    if (mem_we) begin
      we_cnt  <= we_cnt + 1;
      we_addr <= mem_addr;
      we_data <= mem_wdata;
    end
    if (mem_re) re_cnt <= re_cnt + 1;
  end

  int total = 0, failed = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failed = failed + 1;
      total  = total + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [3:0] ob_out [17];
  logic       ob_oe  [17];
  logic [7:0] shadow [256];
  logic       exp_tog = 1'b0;

  task automatic cyc(input logic f, input logic [3:0] n, input int k);
    @(negedge clk);
    frame_n = f;
    lad_in  = n;
    #1;
    if (k >= 0 && k < 17) begin
      ob_out[k] = lad_out;
      ob_oe[k]  = lad_oe;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 4'hF, -1);
  endtask

  task automatic run(input bit wr, input logic [31:0] a, input logic [7:0] d, input logic [3:0] ct);
    cyc(1'b0, 4'h0, 0);
    cyc(1'b1, ct, 1);
    for (int i = 0; i < 8; i++) cyc(1'b1, a[31-4*i -: 4], 2 + i);
    if (wr) begin
      cyc(1'b1, d[3:0], 10);
      cyc(1'b1, d[7:4], 11);
      for (int k = 12; k < 17; k++) cyc(1'b1, 4'hF, k);
    end else begin
      for (int k = 10; k < 17; k++) cyc(1'b1, 4'hF, k);
    end
  endtask

  function automatic int oe_mism(input bit wr, input bit claim);
    int m = 0;
    for (int k = 0; k < 17; k++) begin
      bit e = claim && (wr ? (k == 14 || k == 15) : (k >= 12 && k <= 15));
      if (ob_oe[k] !== e) m++;
    end
    return m;
  endfunction

  task automatic check_read(input logic [31:0] a, input logic [7:0] exp, input string req);
    chk(oe_mism(1'b0, 1'b1) == 0, {req, " R4 oe window"}, oe_mism(1'b0, 1'b1), 0);
    chk(ob_out[12] == 4'h0, "R4 sync nibble", ob_out[12], 0);
    chk(ob_out[13] == exp[3:0], {req, " R2 low nibble first"}, ob_out[13], exp[3:0]);
    chk(ob_out[14] == exp[7:4], {req, " high nibble"}, ob_out[14], exp[7:4]);
    chk(ob_out[15] == 4'hF, "R4 closing ones", ob_out[15], 4'hF);
  endtask

  task automatic do_read(input logic [31:0] a, input logic [7:0] exp, input string req);
    run(1'b0, a, 8'h00, 4'b0100);
    check_read(a, exp, req);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(lad_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R11 outputs in reset",
        {lad_oe, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    exp_tog = 1'b0;
  endtask

  // {wr, claim, addr[31:0], data[7:0]}
  localparam logic [41:0] VEC [11] = '{
    {1'b0, 1'b1, 32'hFFFF_FFFF, 8'h00},
    {1'b0, 1'b1, 32'h000E_0000, 8'h00},
    {1'b1, 1'b1, 32'hFFC0_0010, 8'hA5},
    {1'b0, 1'b1, 32'hFFC0_0010, 8'h00},
    {1'b0, 1'b0, 32'hFFBF_FFFF, 8'h00},
    {1'b0, 1'b0, 32'h000D_FFFF, 8'h00},
    {1'b1, 1'b0, 32'h0010_0000, 8'h3C},
    {1'b0, 1'b1, 32'h000F_FFFF, 8'h00},
    {1'b1, 1'b1, 32'h000E_0022, 8'hC3},
    {1'b0, 1'b1, 32'h000E_0022, 8'h00},
    {1'b0, 1'b0, 32'h1234_5678, 8'h00}
  };

  initial begin
    int w0, r0, cnt;
    logic [7:0] st;
    for (int i = 0; i < 256; i++) shadow[i] = init_byte(i);
    repeat (3) @(negedge clk);
    chk(lad_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R11 reset state",
        {lad_oe, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < 11; v++) begin
      bit wr = VEC[v][41];
      bit cl = VEC[v][40];
      logic [31:0] a = VEC[v][39:8];
      logic [7:0]  d = VEC[v][7:0];
      w0 = we_cnt;
      r0 = re_cnt;
      run(wr, a, d, wr ? 4'b0110 : 4'b0100);
      if (!cl) begin
        chk(oe_mism(wr, 1'b0) == 0, "R3 unclaimed never drives", oe_mism(wr, 1'b0), 0);
        chk(we_cnt == w0 && re_cnt == r0, "R3 unclaimed no strobes", we_cnt - w0 + re_cnt - r0, 0);
      end else if (wr) begin
        chk(oe_mism(1'b1, 1'b1) == 0, "R5 write oe window", oe_mism(1'b1, 1'b1), 0);
        chk(ob_out[14] == 4'h0 && ob_out[15] == 4'hF, "R5 sync then ones",
            {ob_out[14], ob_out[15]}, 8'h0F);
        chk(we_cnt == w0 + 1, "R6 one write strobe", we_cnt - w0, 1);
        chk(we_addr == a[AW-1:0], "R6 write address", we_addr, a[AW-1:0]);
        chk(we_data == d, "R2 R6 write data nibble order", we_data, d);
        shadow[a[7:0]] = d;
        idle(BUSY + 4);
      end else begin
        chk(re_cnt == r0 + 1, "R6 one read strobe", re_cnt - r0, 1);
        check_read(a, shadow[a[7:0]], "R2");
      end
    end

    // R7 R8: status toggling while busy, then array data
    run(1'b1, 32'hFFC0_0040, 8'h77, 4'b0110);
    shadow[8'h40] = 8'h77;
    r0 = re_cnt;
    for (int i = 0; i < 2; i++) begin
      st = {1'b0, exp_tog, 6'b0};
      do_read(32'hFFC0_0041, st, "R7 status");
      exp_tog = ~exp_tog;
    end
    chk(re_cnt == r0, "R7 array not read while busy", re_cnt - r0, 0);
    do_read(32'hFFC0_0041, shadow[8'h41], "R8 array after busy");
    do_read(32'hFFC0_0040, shadow[8'h40], "R8 written byte");

    // R9: write inside busy period
    run(1'b1, 32'hFFC0_0050, 8'h11, 4'b0110);
    shadow[8'h50] = 8'h11;
    w0 = we_cnt;
    run(1'b1, 32'hFFC0_0051, 8'h22, 4'b0110);
    chk(we_cnt == w0, "R9 no strobe while busy", we_cnt - w0, 0);
    chk(ob_oe[14] == 1'b1 && ob_out[14] == 4'h0, "R9 sync still given", ob_out[14], 0);
    idle(BUSY + 4);
    do_read(32'hFFC0_0051, shadow[8'h51], "R9 array unchanged");

    // R1: unsupported cycle type
    w0 = we_cnt;
    r0 = re_cnt;
    run(1'b0, 32'hFFC0_0010, 8'h00, 4'b0000);
    chk(oe_mism(1'b0, 1'b0) == 0, "R1 unsupported type silent", oe_mism(1'b0, 1'b0), 0);
    chk(we_cnt == w0 && re_cnt == r0, "R1 unsupported no strobes", we_cnt - w0 + re_cnt - r0, 0);

    // R10: abort in the address phase, no restart
    cyc(1'b0, 4'h0, -1);
    cyc(1'b1, 4'b0100, -1);
    cyc(1'b1, 4'hF, -1);
    cyc(1'b1, 4'hF, -1);
    cyc(1'b0, 4'hF, -1);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, 4'hF, -1);
      if (lad_oe) cnt++;
    end
    chk(cnt == 0, "R10 aborted cycle silent", cnt, 0);

    // R10: abort with restart in the same clock
    cyc(1'b0, 4'h0, -1);
    cyc(1'b1, 4'b0110, -1);
    cyc(1'b1, 4'hF, -1);
    cyc(1'b1, 4'hF, -1);
    do_read(32'h000E_0030, shadow[8'h30], "R10 restart");

    // R10: abort in the write data phase
    w0 = we_cnt;
    cyc(1'b0, 4'h0, -1);
    cyc(1'b1, 4'b0110, -1);
    for (int i = 0; i < 8; i++) cyc(1'b1, 8'(32'hFFC0_0060 >> (28 - 4*i)), -1);
    cyc(1'b1, 4'h9, -1);
    cyc(1'b0, 4'hF, -1);
    idle(16);
    chk(we_cnt == w0, "R10 aborted write no strobe", we_cnt - w0, 0);
    do_read(32'hFFC0_0060, shadow[8'h60], "R10 array unchanged");

    // R11: reset mid-cycle, then after a write clears busy
    cyc(1'b0, 4'h0, -1);
    cyc(1'b1, 4'b0100, -1);
    cyc(1'b1, 4'hF, -1);
    do_reset();
    do_read(32'h000E_0031, shadow[8'h31], "R11 read after reset");
    run(1'b1, 32'hFFC0_0070, 8'hAB, 4'b0110);
    shadow[8'h70] = 8'hAB;
    do_reset();
    do_read(32'hFFC0_0070, shadow[8'h70], "R11 busy cleared");

    idle(2);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule